// File: doc/BRIEF.md
# Selectable-Ratio Clock Fan-Out Controller

This block turns one timing clock into six differential host clock pairs and one complementary memory-reference pair. Each output is modelled as a data bit plus an output-enable bit per leg. The block runs on `clk`, which ticks at twice the reference rate. An undivided output toggles on every `clk` edge. Divide-by-2 and divide-by-4 outputs take their levels from the same free-running three-bit phase counter, so every rising edge lines up with a rising edge of the undivided output.

A three-bit select code picks a divide ratio for each of three groups. The outer group is the first and last host pairs. The inner group is every other host pair. The third group is the memory pair. A test input tristates every leg. An asynchronous active-low power-down input parks the outputs at fixed levels. After power-down or reset is released, the outputs stay parked for a stabilization count and then resume on a phase boundary. Select and test changes pass through a synchronizer and take effect only where the phase counter wraps. The block has no data stream, so there is no valid/ready interface: every pin is plain control or clock output, and nothing can apply back-pressure.

Top module: `fanout_clock_ctrl`

## Requirements
- R1: A shared phase counter advances by one on every `clk` edge and wraps from 7 to 0. A divide-by-1 output is high on even phases. A divide-by-2 output is high when phase mod 4 < 2. A divide-by-4 output is high when phase < 4. All of them rise together at phase 0.
- R2: `sel_code` = {a,b,u}, with a as the MSB. Ratios are listed as outer/inner/memory. Code 000 gives 2/2/4, code 001 gives tristate/2/4, code 010 gives 4/2/4, and code 011 gives 4/4/4.
- R3: Code 100 gives 1/1/4, code 101 gives tristate/1/4, code 110 gives 2/1/4, and code 111 gives 2/2/2.
- R4: The outer group is host pairs 0 and HOST_PAIRS-1. All other pairs form the inner group. Under code 001, `host_t_oe` and `host_c_oe` both read 6'b011110.
- R5: When the applied test flag is 1 and the outputs are not parked, every enable (`host_t_oe`, `host_c_oe`, `mem_oe`) is 0, whatever the select code.
- R6: While `pd_n` is low, with no clock edge needed, every host true leg is 1 and enabled and every complementary leg is disabled with data 0. `mem_t` is 1, `mem_c` is 0 and `mem_oe` is 1. This overrides the test flag.
- R7: After `pd_n` and `rst_n` are both high, the outputs stay parked for STAB_CYCLES edges. They are released at the first later edge where the phase wraps from 7 to 0.
- R8: `mem_c` is always the inverse of `mem_t`. An enabled host pair drives `host_c` as the inverse of `host_t`. A tristated pair has both enables at 0 and both data bits at 0.
- R9: A new select or test value is captured by two synchronizer flops. It becomes active only at the edge where the phase wraps to 0. Until then the old pattern continues, and the phase counter is never reset by these inputs.
- R10: While `rst_n` is low, the outputs show the parked levels of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down |
| sel_code | input | 3 | Ratio select {a,b,u} |
| test_hiz | input | 1 | Active-high tristate request |
| host_t | output | HOST_PAIRS | Host true leg data |
| host_t_oe | output | HOST_PAIRS | Host true leg enable |
| host_c | output | HOST_PAIRS | Host complementary leg data |
| host_c_oe | output | HOST_PAIRS | Host complementary leg enable |
| mem_t | output | 1 | Memory reference true data |
| mem_c | output | 1 | Memory reference complementary data |
| mem_oe | output | 1 | Memory reference enable (both legs) |

## Verification
Power-down and the test flag can be active in the same cycle. The bench raises `test_hiz`, lets it reach the wrap boundary, and then drops `pd_n` between clock edges. It checks that the outputs take the parked levels before the next edge and keep them, rather than going high impedance. A release from parking and a pending select change can also land on the same phase wrap. The bench changes the select code while the stabilization count runs out. It then compares every output on every cycle against a behavioural model that tracks phase, synchronizer depth and parking on its own.

// File: rtl/fanout_pkg.sv
package fanout_pkg;
  localparam int PHASE_W = 3;

  typedef enum logic [1:0] {RT_DIV1, RT_DIV2, RT_DIV4, RT_OFF} ratio_e;

  typedef struct packed {
    ratio_e outer;
    ratio_e inner;
    ratio_e mem;
  } ratio_set_t;

  function automatic ratio_set_t decode_sel(input logic [2:0] code);
    ratio_set_t rs;
    case (code)
      3'b000:  rs = '{outer: RT_DIV2, inner: RT_DIV2, mem: RT_DIV4};
      3'b001:  rs = '{outer: RT_OFF,  inner: RT_DIV2, mem: RT_DIV4};
      3'b010:  rs = '{outer: RT_DIV4, inner: RT_DIV2, mem: RT_DIV4};
      3'b011:  rs = '{outer: RT_DIV4, inner: RT_DIV4, mem: RT_DIV4};
      3'b100:  rs = '{outer: RT_DIV1, inner: RT_DIV1, mem: RT_DIV4};
      3'b101:  rs = '{outer: RT_OFF,  inner: RT_DIV1, mem: RT_DIV4};
      3'b110:  rs = '{outer: RT_DIV2, inner: RT_DIV1, mem: RT_DIV4};
      default: rs = '{outer: RT_DIV2, inner: RT_DIV2, mem: RT_DIV2};
    endcase
    return rs;
  endfunction

  // Level of a divided output at a given phase; all ratios rise at phase 0.
  function automatic logic ratio_level(input ratio_e r, input logic [PHASE_W-1:0] ph);
    case (r)
      RT_DIV1: return ~ph[0];
      RT_DIV2: return ~ph[1];
      RT_DIV4: return ~ph[2];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fanout_sync.sv
module fanout_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fanout_phase.sv
module fanout_phase
  import fanout_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  output logic [PHASE_W-1:0] phase,
  output logic               wrap_next
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  assign wrap_next = &phase;
endmodule

// File: rtl/fanout_park.sv
module fanout_park #(
  parameter int STAB_CYCLES = 600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic wrap_next,
  output logic parked
);
  localparam int CNT_W = (STAB_CYCLES < 1) ? 1 : $clog2(STAB_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n or negedge pd_n) begin
    if (!rst_n || !pd_n) begin
      cnt    <= CNT_W'(STAB_CYCLES);
      parked <= 1'b1;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (cnt == '0 && wrap_next) parked <= 1'b0;
    end
  end
endmodule

// File: rtl/fanout_clock_ctrl.sv
module fanout_clock_ctrl
  import fanout_pkg::*;
#(
  parameter int HOST_PAIRS  = 6,
  parameter int STAB_CYCLES = 600000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pd_n,
  input  logic [2:0]            sel_code,
  input  logic                  test_hiz,
  output logic [HOST_PAIRS-1:0] host_t,
  output logic [HOST_PAIRS-1:0] host_t_oe,
  output logic [HOST_PAIRS-1:0] host_c,
  output logic [HOST_PAIRS-1:0] host_c_oe,
  output logic                  mem_t,
  output logic                  mem_c,
  output logic                  mem_oe
);
  localparam int CFG_W = 4;

  logic [CFG_W-1:0]   cfg_sync;
  logic [2:0]         act_sel;
  logic               act_test;
  logic [PHASE_W-1:0] phase;
  logic               wrap_next;
  logic               parked;
  logic               hold;
  ratio_set_t         rs;
  logic               lv_mem;

  fanout_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({test_hiz, sel_code}), .q(cfg_sync)
  );

  fanout_phase u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .wrap_next(wrap_next)
  );

  fanout_park #(.STAB_CYCLES(STAB_CYCLES)) u_park (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .wrap_next(wrap_next), .parked(parked)
  );

  // Apply a new configuration only on the wrap to phase 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel  <= '0;
      act_test <= 1'b0;
    end else if (wrap_next) begin
      act_sel  <= cfg_sync[2:0];
      act_test <= cfg_sync[3];
    end
  end

  assign hold   = parked | ~pd_n;
  assign rs     = decode_sel(act_sel);
  assign lv_mem = ratio_level(rs.mem, phase);

  assign mem_t  = hold ? 1'b1 : lv_mem;
  assign mem_c  = ~mem_t;
  assign mem_oe = hold | ~act_test;

  for (genvar g = 0; g < HOST_PAIRS; g++) begin : g_pair
    localparam bit OUTER = (g == 0) || (g == HOST_PAIRS - 1);
    ratio_e r;
    logic   lv;
    logic   off;
    assign r   = OUTER ? rs.outer : rs.inner;
    assign lv  = ratio_level(r, phase);
    assign off = (r == RT_OFF) | act_test;

    assign host_t[g]    = hold ? 1'b1 : (off ? 1'b0 : lv);
    assign host_t_oe[g] = hold | ~off;
    assign host_c[g]    = (hold | off) ? 1'b0 : ~lv;
    assign host_c_oe[g] = ~hold & ~off;
  end
endmodule

// File: rtl/fanout_clock_ctrl_chk.sv
module fanout_clock_ctrl_chk #(
  parameter int HOST_PAIRS = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pd_n,
  input logic                  parked,
  input logic                  act_test,
  input logic [2:0]            act_sel,
  input logic [2:0]            phase,
  input logic [HOST_PAIRS-1:0] host_t,
  input logic [HOST_PAIRS-1:0] host_t_oe,
  input logic [HOST_PAIRS-1:0] host_c_oe,
  input logic                  mem_t,
  input logic                  mem_c
);
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> phase == $past(phase) + 3'd1);

  assert_park_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> (&host_t) && (&host_t_oe) && (host_c_oe == '0) && mem_t && !mem_c);

  assert_test_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && !parked && act_test) |-> (host_t_oe == '0) && (host_c_oe == '0));

  assert_pair_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && !parked) |-> host_t_oe == host_c_oe);

  assert_sel_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_sel) |-> phase == 3'd0);

  assert_release_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_n) |-> parked);
endmodule

bind fanout_clock_ctrl fanout_clock_ctrl_chk #(.HOST_PAIRS(HOST_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .parked(parked), .act_test(act_test),
  .act_sel(act_sel), .phase(phase), .host_t(host_t), .host_t_oe(host_t_oe),
  .host_c_oe(host_c_oe), .mem_t(mem_t), .mem_c(mem_c)
);

// File: tb/tb_fanout_clock_ctrl.sv
`timescale 1ns/1ps
module tb_fanout_clock_ctrl;
  localparam int N    = 6;
  localparam int STAB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1;
  logic [2:0] sel_code = 3'd0;
  logic test_hiz = 1'b0;
  logic [N-1:0] host_t, host_t_oe, host_c, host_c_oe;
  logic mem_t, mem_c, mem_oe;

  always #5 clk = ~clk;

  fanout_clock_ctrl #(.HOST_PAIRS(N), .STAB_CYCLES(STAB)) dut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .sel_code(sel_code), .test_hiz(test_hiz),
    .host_t(host_t), .host_t_oe(host_t_oe), .host_c(host_c), .host_c_oe(host_c_oe),
    .mem_t(mem_t), .mem_c(mem_c), .mem_oe(mem_oe)
  );

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mph = 0;
  int mcnt = STAB;
  bit mparked = 1;
  logic [2:0] msel = 0;
  bit mtest = 0;
  logic [3:0] syncq[$] = '{4'd0, 4'd0};

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mcnt = STAB; mparked = 1; msel = 0; mtest = 0;
      syncq = '{4'd0, 4'd0};
    end else begin
      if (mph == 7) begin
        msel  = syncq[0][2:0];
        mtest = syncq[0][3];
      end
      void'(syncq.pop_front());
      syncq.push_back({test_hiz, sel_code});
      if (mcnt == 0 && mph == 7) mparked = 0;
      if (mcnt > 0) mcnt = mcnt - 1;
      mph = (mph + 1) % 8;
      if (!pd_n) begin mcnt = STAB; mparked = 1; end
    end
  end

  // ratio codes: 0 = tristate, otherwise divide value
  function automatic void ratios(input logic [2:0] s, output int ro, output int ri, output int rm);
    case (s)
      0: begin ro = 2; ri = 2; rm = 4; end
      1: begin ro = 0; ri = 2; rm = 4; end
      2: begin ro = 4; ri = 2; rm = 4; end
      3: begin ro = 4; ri = 4; rm = 4; end
      4: begin ro = 1; ri = 1; rm = 4; end
      5: begin ro = 0; ri = 1; rm = 4; end
      6: begin ro = 2; ri = 1; rm = 4; end
      default: begin ro = 2; ri = 2; rm = 2; end
    endcase
  endfunction

  function automatic bit lvl(input int r, input int ph);
    return (ph % (2 * r)) < r;
  endfunction

  always @(posedge clk) begin
    int ro, ri, rm, r;
    bit hold;
    logic [N-1:0] et, eto, ec, eco;
    logic em, emo;
    string tag;
    #2;
    hold = mparked || !pd_n;
    ratios(msel, ro, ri, rm);
    for (int i = 0; i < N; i++) begin
      r = (i == 0 || i == N - 1) ? ro : ri;
      if (hold) begin et[i] = 1; eto[i] = 1; ec[i] = 0; eco[i] = 0; end
      else if (r == 0 || mtest) begin et[i] = 0; eto[i] = 0; ec[i] = 0; eco[i] = 0; end
      else begin et[i] = lvl(r, mph); ec[i] = !et[i]; eto[i] = 1; eco[i] = 1; end
    end
    em  = hold ? 1'b1 : lvl(rm, mph);
    emo = hold || !mtest;
    if (!rst_n) tag = "R10";
    else if (!pd_n) tag = "R6";
    else if (mparked) tag = "R7";
    else if (mtest) tag = "R5";
    else if (msel < 4) tag = "R2";
    else tag = "R3";
    chk({host_t, host_t_oe, host_c, host_c_oe, mem_t, mem_c, mem_oe} ===
        {et, eto, ec, eco, em, !em, emo}, tag,
        64'({host_t, host_t_oe, host_c, host_c_oe, mem_t, mem_c, mem_oe}),
        64'({et, eto, ec, eco, em, !em, emo}));
    // R8: complementary legs
    chk(mem_c === ~mem_t && ((host_c & host_c_oe) === (~host_t & host_c_oe)), "R8",
        64'({mem_c, host_c}), 64'({~mem_t, ~host_t & host_c_oe}));
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(host_t === '1 && host_c_oe === '0 && mem_t === 1'b1 && mem_c === 1'b0, "R10",
        64'({host_t, host_c_oe, mem_t, mem_c}), 64'({{N{1'b1}}, {N{1'b0}}, 2'b10}));
    @(negedge clk) rst_n = 1;
    wait_cycles(40);

    for (int c = 0; c < 8; c++) begin
      @(negedge clk) sel_code = 3'(c);
      wait_cycles(24);
      if (c == 1) begin
        chk(host_t_oe === 6'b011110 && host_c_oe === 6'b011110, "R4",
            64'({host_t_oe, host_c_oe}), 64'({6'b011110, 6'b011110}));
      end
      if (c == 6) begin
        // R1: at a rising edge of mem (divide-by-4), all divided outputs are high
        for (int k = 0; k < 16; k++) begin
          logic pm;
          pm = mem_t;
          @(negedge clk);
          if (!pm && mem_t)
            chk(host_t[0] && host_t[1] && mph == 0, "R1",
                64'({host_t[1:0], 3'(mph)}), 64'({2'b11, 3'd0}));
        end
      end
    end

    // R9: switch 000 -> 011 right after the wrap; old pattern holds for phases 1..7
    @(negedge clk) sel_code = 3'd0;
    wait_cycles(24);
    while (mph != 0) @(negedge clk);
    sel_code = 3'd3;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(host_t[0] === lvl(2, mph), "R9", 64'(host_t[0]), 64'(lvl(2, mph)));
    end
    wait_cycles(16);

    // R5: test tristate under code 101
    @(negedge clk) begin sel_code = 3'd5; test_hiz = 1; end
    wait_cycles(20);
    chk(host_t_oe === '0 && host_c_oe === '0 && mem_oe === 1'b0, "R5",
        64'({host_t_oe, host_c_oe, mem_oe}), 64'(0));

    // R6: asynchronous power-down, with test still high (priority)
    @(posedge clk);
    #3 pd_n = 0;
    #1;
    chk(host_t === '1 && host_t_oe === '1 && host_c_oe === '0 && mem_t === 1'b1 &&
        mem_c === 1'b0 && mem_oe === 1'b1, "R6",
        64'({host_t, host_t_oe, host_c_oe, mem_t, mem_c, mem_oe}),
        64'({{N{1'b1}}, {N{1'b1}}, {N{1'b0}}, 3'b101}));
    wait_cycles(6);
    @(negedge clk) begin test_hiz = 0; pd_n = 1; sel_code = 3'd7; end
    // R7: stays parked for the stabilization count
    for (int k = 0; k < STAB; k++) begin
      @(negedge clk);
      chk(host_c_oe === '0 && mem_t === 1'b1, "R7", 64'({host_c_oe, mem_t}), 64'(1));
    end
    wait_cycles(40);

    // coincidence: release while a select change is pending
    @(negedge clk) pd_n = 0;
    wait_cycles(3);
    @(negedge clk) pd_n = 1;
    wait_cycles(STAB - 3);
    @(negedge clk) sel_code = 3'd4;
    wait_cycles(40);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule